// File: doc/BRIEF.md
# Adaptive Scan Shift Rate Controller

This block paces the scan-in phase of a built-in self-test engine. It produces a shift-enable strobe on a single master clock, and it raises the strobe rate while a test vector is loaded, as the loaded data proves to be quiet. A quiet stream has few bit changes, so it toggles few scan cells. Each chain has a monitor that counts non-transitions, meaning a bit equal to the previous bit shifted into the same chain. A divider offers four strobe rates: one shift every 8, 4, 2 or 1 master cycles. A selector moves one rate step faster whenever every chain's count has reached the next multiple of a step threshold.

A vector begins with a `start` pulse and always begins at the slowest rate. The threshold is the total flip-flop count divided by a step divisor. The busiest chain sets the pace, because a step needs every chain to qualify. Once all chain cells are loaded, the block pulses `shiftDone` and becomes idle. It waits there for the next `start`. At that point the rate and the counters are cleared again.

Top module: `adscan_clock_ctrl`

## Requirements
- R1: After reset, `shiftEn`, `shiftDone` and `busy` are 0 and `rateLevel` is 0.
- R2: A `start` pulse seen while idle sets `busy` and rate level 0 on the next edge. The first `shiftEn` is then high in the 8th cycle after that edge.
- R3: Each chain counts a non-transition when the bit it samples on a shift equals that chain's bit from the previous shift of the same vector. The first bit of a vector never counts.
- R4: On a shift, the level rises by exactly one when every chain's count, with that shift included, is at least (level+1)×THRESH, where THRESH = NUM_CHAINS×CHAIN_LEN/STEP_DIV. The level never exceeds 3 and only changes on a shift edge.
- R5: At level L, consecutive `shiftEn` strobes are 2^(3−L) cycles apart. Level 0 is the slowest rate and level 3 is one shift per cycle.
- R6: Each vector has exactly CHAIN_LEN shifts. `shiftDone` is high for exactly one cycle, the cycle after the last shift. `shiftEn` is low in that cycle.
- R7: A `start` pulse while `busy` is high is ignored. It changes neither the shift count nor the spacing of the strobes.
- R8: `busy` stays high from the cycle after an accepted `start` through the last shift. `shiftEn` is never high while `busy` is low.
- R9: Every new vector restarts at level 0 with cleared counts, whatever level the previous vector reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin loading one vector (taken only while idle) |
| scanBits | input | NUM_CHAINS | Next bit entering each chain, sampled on a `shiftEn` cycle |
| shiftEn | output | 1 | Shift strobe: the chains shift on the edge that ends this cycle |
| shiftDone | output | 1 | One-cycle pulse after the last shift of a vector |
| busy | output | 1 | A vector load is in progress |
| rateLevel | output | 2 | Current rate step, 0 = divide by 8 to 3 = every cycle |

## Verification
After the edge that accepts `start`, the first strobe is due exactly 8 cycles later. After any strobe, the next one is due exactly 2^(3−L) cycles later, where L is the level shown during the strobe cycle. The level itself is due one edge after the shift that qualifies it, and `shiftDone` is due one edge after the last shift. The bench keeps a cycle counter that restarts at each strobe and samples all outputs on the falling clock edge. It computes the required gap and level from its own running count of non-transitions per chain. The stimulus covers runs of equal bits, alternating streams, mixed chains where one chain holds the rate back, and a sweep of run-length patterns.

// File: rtl/adscan_pkg.sv
package adscan_pkg;

  // Strobes from the control path to the inactivity monitors
  typedef struct packed {
    logic clearStats;   // new vector: clear counts and history
    logic sampleBit;    // a shift happens on this edge
  } monStrobe_t;

endpackage

// File: rtl/adscan_rate_gen.sv
// Divider taps and rate selector: one shift strobe per selected period.
module adscan_rate_gen #(
  parameter int NUM_LEVELS = 4,
  localparam int DIV_W = NUM_LEVELS - 1,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             restart,
  input  logic [LVL_W-1:0] level,
  output logic             shiftTick
);

  logic [DIV_W-1:0]      divCnt;
  logic [NUM_LEVELS-1:0] tap;

  // Tap for level l fires once every 2^(NUM_LEVELS-1-l) cycles
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_tap
    localparam int K = DIV_W - l;
    if (K == 0) begin : g_every
      assign tap[l] = 1'b1;
    end else begin : g_div
      assign tap[l] = &divCnt[K-1:0];
    end
  end

  assign shiftTick = run && tap[level];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (restart || shiftTick) begin
      divCnt <= '0;
    end else if (run) begin
      divCnt <= divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/adscan_monitor.sv
// Per-chain inactivity monitors with the step-up qualification.
module adscan_monitor
  import adscan_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 10,
  parameter int THRESH     = 2,
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W  = $clog2(NUM_LEVELS),
  localparam int CNT_W  = $clog2(CHAIN_LEN + 1),
  localparam int MARK_W = $clog2((NUM_LEVELS + 1) * THRESH + CHAIN_LEN + 2)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  monStrobe_t            strobe,
  input  logic [NUM_CHAINS-1:0] scanBits,
  input  logic [LVL_W-1:0]      level,
  output logic                  allReach
);

  logic                  havePrev;
  logic [NUM_CHAINS-1:0] reach;
  logic [MARK_W-1:0]     mark;

  assign mark     = (MARK_W'(level) + MARK_W'(1)) * MARK_W'(THRESH);
  assign allReach = &reach;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      havePrev <= 1'b0;
    end else if (strobe.clearStats) begin
      havePrev <= 1'b0;
    end else if (strobe.sampleBit) begin
      havePrev <= 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    logic             prevBit;
    logic [CNT_W-1:0] quietCnt;
    logic [CNT_W-1:0] nextCnt;
    logic             same;

    assign same    = havePrev && (scanBits[c] == prevBit);
    assign nextCnt = quietCnt + CNT_W'(same);
    assign reach[c] = MARK_W'(nextCnt) >= mark;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevBit  <= 1'b0;
        quietCnt <= '0;
      end else if (strobe.clearStats) begin
        prevBit  <= 1'b0;
        quietCnt <= '0;
      end else if (strobe.sampleBit) begin
        prevBit  <= scanBits[c];
        quietCnt <= nextCnt;
      end
    end
  end

endmodule

// File: rtl/adscan_ctrl.sv
// Vector sequencing, bit counting and rate level.
module adscan_ctrl
  import adscan_pkg::*;
#(
  parameter int CHAIN_LEN  = 10,
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W = $clog2(NUM_LEVELS),
  localparam int BIT_W = $clog2(CHAIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             shiftTick,
  input  logic             allReach,
  output monStrobe_t       strobe,
  output logic [LVL_W-1:0] level,
  output logic             busy,
  output logic             shiftDone
);

  typedef enum logic {ST_IDLE, ST_SHIFT} state_t;

  localparam logic [LVL_W-1:0] MAX_LEVEL = LVL_W'(NUM_LEVELS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(CHAIN_LEN - 1);

  state_t           state;
  logic [BIT_W-1:0] bitCnt;

  assign busy              = (state == ST_SHIFT);
  assign strobe.clearStats = start && !busy;
  assign strobe.sampleBit  = shiftTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      level     <= '0;
      shiftDone <= 1'b0;
    end else begin
      shiftDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
            level  <= '0;
          end
        end
        ST_SHIFT: begin
          if (shiftTick) begin
            bitCnt <= bitCnt + 1'b1;
            if (allReach && level != MAX_LEVEL) begin
              level <= level + 1'b1;
            end
            if (bitCnt == LAST_BIT) begin
              state     <= ST_IDLE;
              shiftDone <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adscan_clock_ctrl.sv
// Top: adaptive scan shift rate controller.
module adscan_clock_ctrl
  import adscan_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 10,
  parameter int STEP_DIV   = 10,
  parameter int NUM_LEVELS = 4,
  localparam int TOTAL_FF = NUM_CHAINS * CHAIN_LEN,
  localparam int THRESH   = (TOTAL_FF / STEP_DIV) < 1 ? 1 : (TOTAL_FF / STEP_DIV),
  localparam int LVL_W    = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [NUM_CHAINS-1:0] scanBits,
  output logic                  shiftEn,
  output logic                  shiftDone,
  output logic                  busy,
  output logic [LVL_W-1:0]      rateLevel
);

  monStrobe_t strobe;
  logic       allReach;

  adscan_ctrl #(
    .CHAIN_LEN (CHAIN_LEN),
    .NUM_LEVELS(NUM_LEVELS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .shiftTick(shiftEn),
    .allReach (allReach),
    .strobe   (strobe),
    .level    (rateLevel),
    .busy     (busy),
    .shiftDone(shiftDone)
  );

  adscan_rate_gen #(
    .NUM_LEVELS(NUM_LEVELS)
  ) u_rate (
    .clk      (clk),
    .rstN     (rstN),
    .run      (busy),
    .restart  (strobe.clearStats),
    .level    (rateLevel),
    .shiftTick(shiftEn)
  );

  adscan_monitor #(
    .NUM_CHAINS(NUM_CHAINS),
    .CHAIN_LEN (CHAIN_LEN),
    .THRESH    (THRESH),
    .NUM_LEVELS(NUM_LEVELS)
  ) u_mon (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .scanBits(scanBits),
    .level   (rateLevel),
    .allReach(allReach)
  );

endmodule

// File: rtl/adscan_clock_ctrl_chk.sv
module adscan_clock_ctrl_chk #(
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             shiftEn,
  input logic             shiftDone,
  input logic             busy,
  input logic [LVL_W-1:0] rateLevel
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftDone |=> !shiftDone);

  // R6
  done_follows_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftDone |-> ($past(shiftEn) && !shiftEn));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !shiftEn);

  // R2
  start_slow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && rateLevel == '0));

  // R4
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |->
      ({1'b0, rateLevel} == {1'b0, $past(rateLevel)} ||
       {1'b0, rateLevel} == {1'b0, $past(rateLevel)} + 1'b1));

  // R4
  level_on_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && rateLevel != $past(rateLevel)) |-> $past(shiftEn));

endmodule

bind adscan_clock_ctrl adscan_clock_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .shiftEn  (shiftEn),
  .shiftDone(shiftDone),
  .busy     (busy),
  .rateLevel(rateLevel)
);

// File: tb/sim_adscan_clock_ctrl.sv
module sim_adscan_clock_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CH   = 2;
  localparam int LEN  = 10;
  localparam int SDIV = 10;
  localparam int TH   = (CH * LEN) / SDIV;
  localparam int MAXL = 3;
  localparam int NVEC = 36;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CH-1:0] scanBits = '0;
  logic          shiftEn, shiftDone, busy;
  logic [1:0]    rateLevel;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adscan_clock_ctrl #(
    .NUM_CHAINS(CH), .CHAIN_LEN(LEN), .STEP_DIV(SDIV), .NUM_LEVELS(4)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .scanBits(scanBits),
    .shiftEn(shiftEn), .shiftDone(shiftDone), .busy(busy), .rateLevel(rateLevel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Bit i of vector v entering chain c
  function automatic logic patBit(input int v, input int c, input int i);
    logic [LEN-1:0] a, b;
    int run;
    a = 10'b0011001100;
    b = 10'b1010010100;
    case (v)
      0: return 1'b0;
      1: return 1'(i % 2);
      2: return (c == 0) ? 1'b0 : 1'(i % 2);
      3: return (c == 0) ? a[LEN-1-i] : b[LEN-1-i];
      4: return 1'b1;
      default: begin
        run = 1 + ((v + c) % 4);
        return 1'(((i / run) + v + c) % 2) ^ 1'(((v * 13 + i * 5 + c) % 7) == 0);
      end
    endcase
  endfunction

  task automatic driveBits(input int v, input int i);
    for (int c = 0; c < CH; c++) scanBits[c] = (i < LEN) ? patBit(v, c, i) : 1'b0;
  endtask

  task automatic runVector(input int v, input bit poke);
    int gap, idx, lvl, it;
    int cnt[CH];
    logic prevB[CH];
    bit shot, done, allOk;
    for (int c = 0; c < CH; c++) begin cnt[c] = 0; prevB[c] = 1'b0; end
    driveBits(v, 0);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    gap = 0; idx = 0; lvl = 0; done = 0;
    for (it = 0; it < 200 && !done; it++) begin
      @(negedge clk);
      gap++;
      shot = 0;
      if (shiftDone) begin
        chk(idx == LEN, "R6 shift count", idx, LEN);
        chk(!shiftEn, "R6 no strobe with done", shiftEn, 0);
        chk(!busy, "R8 busy clear at done", busy, 0);
        done = 1;
      end else begin
        chk(busy, "R8 busy during load", busy, 1);
        if (shiftEn) begin
          if (idx == 0) chk(gap == 8, "R2 R9 first strobe gap", gap, 8);
          else chk(gap == (8 >> lvl), "R5 strobe gap", gap, 8 >> lvl);
          chk(rateLevel == 2'(lvl), "R3 R4 rate level", rateLevel, lvl);
          chk(idx < LEN, "R6 extra shift", idx, LEN - 1);
          // model: count non-transitions, then qualify a step
          allOk = 1;
          for (int c = 0; c < CH; c++) begin
            if (idx > 0 && scanBits[c] == prevB[c]) cnt[c]++;
            prevB[c] = scanBits[c];
            if (cnt[c] < (lvl + 1) * TH) allOk = 0;
          end
          if (allOk && lvl < MAXL) lvl++;
          idx++;
          gap = 0;
          shot = 1;
        end
        if (poke && idx == 3 && gap == 1) start = 1'b1;  // R7: ignored
      end
      @(posedge clk);
      #1 start = 1'b0;
      if (shot) driveBits(v, idx);
    end
    chk(done, "R6 done pulse seen", done, 1);
    // R6 / R8: quiet between vectors
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!shiftEn && !shiftDone, "R6 idle after done", shiftEn, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!shiftEn && !shiftDone && !busy, "R1 reset outputs", {shiftEn, shiftDone, busy}, 0);
    chk(rateLevel == 0, "R1 reset level", rateLevel, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !shiftEn, "R1 idle after reset", busy, 0);
    for (int v = 0; v < NVEC; v++) runVector(v, (v % 3) == 1);
    runVector(0, 1'b1);  // R9: saturated vector followed by restart
    runVector(1, 1'b0);
    finished = 1;
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < 150000 && !finished; cyc++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule